// File: doc/BRIEF.md
# Positional Operand Belt

This block stores operands for an execution core by age instead of by register name. It holds a fixed number of entries in order from the newest to the oldest. In each clock cycle the freshly produced values are pushed in at the front. The same number of the oldest entries fall off the far end, so the belt length never changes. Consumers name an operand by its distance from the front. Every push therefore moves each surviving value deeper, and its index grows by the number of values inserted.

Each cycle the block accepts up to `NWR` insertions. They come from two sources: result ports carrying newly computed values, and save ports that copy an existing entry, chosen by position, back onto the front. Read ports look up entries by position without a clock edge. Reads and saves always see the contents from before the current cycle's insertions. An entry that was never written reads as zero and flags an error. A cycle that asks for more insertions than `NWR` keeps the highest-priority ones, drops the rest and raises an overflow flag.

Top module: `belt_queue`

## Requirements
- R1: While synchronous reset is high at a clock edge, every entry becomes empty, so after reset a read at any position returns 0 with its error flag high.
- R2: A single result on port 0 with no saves lands at position 0 on the next edge, and the entry that was at position p moves to p+1.
- R3: All valid insertions of a cycle enter together, and every older entry moves deeper by their count. Result ports with lower index sit nearer the front. An idle result port leaves no gap: a lone value on port 1 lands at position 0.
- R4: Entries pushed beyond position DEPTH-1 are discarded. After DEPTH+4 single pushes, position DEPTH-1 holds the fifth value pushed.
- R5: Read ports are combinational and show the contents from before the insertions taking effect at the coming edge.
- R6: An enabled read of an empty position returns 0 and raises that port's error flag. A disabled read port never raises its error flag.
- R7: A save port copies the entry at its position onto the front in the same cycle as that cycle's results. Saved values sit ahead of results, and save port 0 sits ahead of save port 1.
- R8: If saves plus results in one cycle exceed NWR, the first NWR in priority order are kept. The order is saves by port, then results by port. The rest are dropped, and the overflow flag is high during that cycle only.
- R9: In a cycle with no valid save or result, the contents are left unchanged.
- R10: Saving an empty position raises that save port's error flag in the same cycle and inserts an empty entry, which later reads as 0 with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_vld | input | NWR | Valid bit per result port |
| wr_data | input | NWR x 32 | Result value per port |
| sv_vld | input | NSV | Valid bit per save port |
| sv_pos | input | NSV x log2(DEPTH) | Position to copy per save port |
| rd_en | input | NRD | Enable per read port |
| rd_pos | input | NRD x log2(DEPTH) | Position to read per read port |
| rd_data | output | NRD x 32 | Value at the requested position, 0 if empty |
| rd_err | output | NRD | Enabled read hit an empty position |
| sv_err | output | NSV | Save hit an empty position |
| ins_ovf | output | 1 | Insertions requested this cycle exceed NWR |

## Verification
The sensitive overlap is a save and a result insertion in the same cycle. The save must take its operand from the old position while the whole belt is shifting under it, and it must land ahead of the result. The bench provokes this with saves of deep positions alongside one or two results. It also adds a third and fourth insertion in the same cycle, so that overflow truncation meets the save ordering. Every position is then read back and compared with a shift model kept in the bench. In the cycle of insertion, position 0 is read to confirm that it still shows the old front.

// File: rtl/belt_pkg.sv
package belt_pkg;

    parameter int unsigned BELT_DW = 32;

    typedef struct packed {
        logic               vld;
        logic [BELT_DW-1:0] val;
    } belt_entry_t;

    function automatic belt_entry_t mk_entry(input logic v, input logic [BELT_DW-1:0] d);
        belt_entry_t e;
        e.vld = v;
        e.val = d;
        return e;
    endfunction

endpackage

// File: rtl/belt_tap.sv
module belt_tap
    import belt_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  belt_entry_t [DEPTH-1:0] q,
    input  logic                    en,
    input  logic [PW-1:0]           pos,
    output logic [BELT_DW-1:0]      data,
    output logic                    err
);

    belt_entry_t hit;

    always_comb begin
        hit  = q[pos];
        data = hit.vld ? hit.val : '0;
        err  = en & ~hit.vld;
    end

endmodule

// File: rtl/belt_ins_pack.sv
module belt_ins_pack
    import belt_pkg::*;
#(
    parameter int unsigned NWR = 2,
    parameter int unsigned NSV = 2,
    localparam int unsigned NC = NSV + NWR,
    localparam int unsigned CW = $clog2(NC + 1)
) (
    input  belt_entry_t [NSV-1:0]              sv_ent,
    input  logic        [NSV-1:0]              sv_vld,
    input  logic        [NWR-1:0]              wr_vld,
    input  logic        [NWR-1:0][BELT_DW-1:0] wr_data,
    output belt_entry_t [NWR-1:0]              slot,
    output logic        [CW-1:0]               n_acc,
    output logic                               ovf
);

    belt_entry_t [NC-1:0] cand;
    logic        [NC-1:0] cand_v;
    logic        [CW-1:0] cnt;

    // Priority order: saves first (port 0 foremost), then results by port.
    for (genvar s = 0; s < NSV; s++) begin : g_sv
        assign cand[s]   = sv_ent[s];
        assign cand_v[s] = sv_vld[s];
    end
    for (genvar w = 0; w < NWR; w++) begin : g_wr
        assign cand[NSV+w]   = mk_entry(1'b1, wr_data[w]);
        assign cand_v[NSV+w] = wr_vld[w];
    end

    always_comb begin
        cnt  = '0;
        slot = '0;
        for (int c = 0; c < NC; c++) begin
            if (cand_v[c]) begin
                for (int j = 0; j < NWR; j++) begin
                    if (cnt == CW'(j)) slot[j] = cand[c];
                end
                cnt = cnt + 1'b1;
            end
        end
        ovf   = (cnt > CW'(NWR));
        n_acc = ovf ? CW'(NWR) : cnt;
    end

endmodule

// File: rtl/belt_store.sv
module belt_store
    import belt_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NWR   = 2,
    parameter int unsigned CW    = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  belt_entry_t [NWR-1:0]   slot,
    input  logic        [CW-1:0]    n_acc,
    output belt_entry_t [DEPTH-1:0] q
);

    belt_entry_t [DEPTH-1:0] nxt;

    for (genvar p = 0; p < DEPTH; p++) begin : g_pos
        belt_entry_t [NWR:0] opt;
        assign opt[0] = q[p];
        for (genvar k = 1; k <= NWR; k++) begin : g_shift
            if (p < k) begin : g_new
                assign opt[k] = slot[p];
            end else begin : g_old
                assign opt[k] = q[p-k];
            end
        end
        always_comb begin
            nxt[p] = opt[0];
            for (int k = 1; k <= NWR; k++) begin
                if (n_acc == CW'(k)) nxt[p] = opt[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/belt_queue.sv
module belt_queue
    import belt_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NWR   = 2,
    parameter int unsigned NRD   = 3,
    parameter int unsigned NSV   = 2,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(NSV + NWR + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NWR-1:0]                wr_vld,
    input  logic [NWR-1:0][BELT_DW-1:0]   wr_data,
    input  logic [NSV-1:0]                sv_vld,
    input  logic [NSV-1:0][PW-1:0]        sv_pos,
    input  logic [NRD-1:0]                rd_en,
    input  logic [NRD-1:0][PW-1:0]        rd_pos,
    output logic [NRD-1:0][BELT_DW-1:0]   rd_data,
    output logic [NRD-1:0]                rd_err,
    output logic [NSV-1:0]                sv_err,
    output logic                          ins_ovf
);

    belt_entry_t [DEPTH-1:0] belt_q;
    belt_entry_t [NSV-1:0]   sv_ent;
    logic [NSV-1:0][BELT_DW-1:0] sv_val;
    belt_entry_t [NWR-1:0]   slot;
    logic [CW-1:0]           n_acc;

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        belt_tap #(.DEPTH(DEPTH)) u_tap (
            .q    (belt_q),
            .en   (rd_en[i]),
            .pos  (rd_pos[i]),
            .data (rd_data[i]),
            .err  (rd_err[i])
        );
    end

    for (genvar i = 0; i < NSV; i++) begin : g_sv
        belt_tap #(.DEPTH(DEPTH)) u_tap (
            .q    (belt_q),
            .en   (sv_vld[i]),
            .pos  (sv_pos[i]),
            .data (sv_val[i]),
            .err  (sv_err[i])
        );
        assign sv_ent[i] = mk_entry(~sv_err[i], sv_val[i]);
    end

    belt_ins_pack #(.NWR(NWR), .NSV(NSV)) u_pack (
        .sv_ent  (sv_ent),
        .sv_vld  (sv_vld),
        .wr_vld  (wr_vld),
        .wr_data (wr_data),
        .slot    (slot),
        .n_acc   (n_acc),
        .ovf     (ins_ovf)
    );

    belt_store #(.DEPTH(DEPTH), .NWR(NWR), .CW(CW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .slot  (slot),
        .n_acc (n_acc),
        .q     (belt_q)
    );

endmodule

// File: rtl/belt_queue_chk.sv
module belt_queue_chk
    import belt_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NWR   = 2,
    parameter int unsigned NRD   = 3,
    parameter int unsigned NSV   = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NWR-1:0]              wr_vld,
    input logic [NWR-1:0][BELT_DW-1:0] wr_data,
    input logic [NSV-1:0]              sv_vld,
    input logic [NRD-1:0][BELT_DW-1:0] rd_data,
    input logic [NRD-1:0]              rd_err,
    input logic                        ins_ovf,
    input belt_entry_t [DEPTH-1:0]     belt_q
);

    logic [DEPTH-1:0] vmask;
    always_comb begin
        for (int p = 0; p < DEPTH; p++) vmask[p] = belt_q[p].vld;
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vmask == '0));  // R1

    AST_FRONT_PUSH: assert property (@(posedge clk) disable iff (rst)
        (wr_vld == NWR'(1) && sv_vld == '0) |=>
        (belt_q[0].vld && belt_q[0].val == $past(wr_data[0]) && belt_q[1] == $past(belt_q[0])));  // R2

    AST_FULL_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (wr_vld == '1 && sv_vld == '0) |=> (belt_q[NWR] == $past(belt_q[0])));  // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_vld == '0 && sv_vld == '0) |=> $stable(belt_q));  // R9

    AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (rst)
        ins_ovf |-> (($countones(wr_vld) + $countones(sv_vld)) > NWR));  // R8

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
            rd_err[i] |-> (rd_data[i] == '0));  // R6
    end

endmodule

bind belt_queue belt_queue_chk #(
    .DEPTH(DEPTH), .NWR(NWR), .NRD(NRD), .NSV(NSV)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_vld  (wr_vld),
    .wr_data (wr_data),
    .sv_vld  (sv_vld),
    .rd_data (rd_data),
    .rd_err  (rd_err),
    .ins_ovf (ins_ovf),
    .belt_q  (belt_q)
);

// File: tb/belt_queue_tb_top.sv
module belt_queue_tb_top;
    import belt_pkg::*;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;
    localparam int NWR   = 2;
    localparam int NRD   = 3;
    localparam int NSV   = 2;
    localparam int PW    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NWR-1:0]              wr_vld;
    logic [NWR-1:0][BELT_DW-1:0] wr_data;
    logic [NSV-1:0]              sv_vld;
    logic [NSV-1:0][PW-1:0]      sv_pos;
    logic [NRD-1:0]              rd_en;
    logic [NRD-1:0][PW-1:0]      rd_pos;
    logic [NRD-1:0][BELT_DW-1:0] rd_data;
    logic [NRD-1:0]              rd_err;
    logic [NSV-1:0]              sv_err;
    logic                        ins_ovf;

    always #(CLK_P/2) clk = ~clk;

    belt_queue #(.DEPTH(DEPTH), .NWR(NWR), .NRD(NRD), .NSV(NSV)) dut_i (
        .clk(clk), .rst(rst), .wr_vld(wr_vld), .wr_data(wr_data),
        .sv_vld(sv_vld), .sv_pos(sv_pos), .rd_en(rd_en), .rd_pos(rd_pos),
        .rd_data(rd_data), .rd_err(rd_err), .sv_err(sv_err), .ins_ovf(ins_ovf)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic        mv [DEPTH];
    logic [31:0] md [DEPTH];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < DEPTH; i++) begin
            mv[i] = 1'b0;
            md[i] = '0;
        end
    endtask

    // One insertion cycle; expected flags and new contents follow R3, R7, R8, R10.
    task automatic ins(input logic [1:0] wv, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sv, input logic [3:0] p0, input logic [3:0] p1,
                       input string req);
        logic        lv [4];
        logic [31:0] ld [4];
        int n = 0;
        logic exp_ovf;
        logic [1:0] exp_se;
        @(negedge clk);
        wr_vld = wv; wr_data[0] = a; wr_data[1] = b;
        sv_vld = sv; sv_pos[0] = p0; sv_pos[1] = p1;
        rd_en = 3'b100; rd_pos[2] = '0;
        #1;
        exp_se[0] = sv[0] && !mv[p0];
        exp_se[1] = sv[1] && !mv[p1];
        if (sv[0]) begin lv[n] = mv[p0]; ld[n] = mv[p0] ? md[p0] : 32'h0; n++; end
        if (sv[1]) begin lv[n] = mv[p1]; ld[n] = mv[p1] ? md[p1] : 32'h0; n++; end
        if (wv[0]) begin lv[n] = 1'b1; ld[n] = a; n++; end
        if (wv[1]) begin lv[n] = 1'b1; ld[n] = b; n++; end
        exp_ovf = (n > NWR);
        check(req, "overflow flag", {31'b0, ins_ovf}, {31'b0, exp_ovf});
        check(req, "save error", {30'b0, sv_err}, {30'b0, exp_se});
        check("R5", "front read during insert", rd_data[2], mv[0] ? md[0] : 32'h0);
        check("R5", "front err during insert", {31'b0, rd_err[2]}, {31'b0, !mv[0]});
        if (n > NWR) n = NWR;
        for (int i = DEPTH-1; i >= n; i--) begin
            mv[i] = mv[i-n];
            md[i] = md[i-n];
        end
        for (int i = 0; i < n; i++) begin
            mv[i] = lv[i];
            md[i] = ld[i];
        end
        @(posedge clk);
        #1;
        wr_vld = '0; sv_vld = '0; rd_en = '0;
    endtask

    task automatic cmp_all(input string req);
        for (int p = 0; p < DEPTH; p++) begin
            int port = p % NRD;
            @(negedge clk);
            rd_en = '0;
            rd_en[port] = 1'b1;
            rd_pos[port] = PW'(p);
            #1;
            check(req, $sformatf("data at %0d", p), rd_data[port], mv[p] ? md[p] : 32'h0);
            check(req, $sformatf("err at %0d", p), {31'b0, rd_err[port]}, {31'b0, !mv[p]});
        end
        @(negedge clk);
        rd_en = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mdl_clear();
        cmp_all("R1");
        @(negedge clk);
        rd_en = '0; rd_pos[1] = 4'd5;
        #1;
        check("R6", "err with read disabled", {31'b0, rd_err[1]}, 32'h0);
        rd_en[1] = 1'b1;
        #1;
        check("R6", "empty read data", rd_data[1], 32'h0);
        check("R6", "empty read err", {31'b0, rd_err[1]}, 32'h1);
        rd_en = '0;
    endtask

    task automatic t_single();
        for (int i = 0; i < 5; i++) ins(2'b01, 32'h100 + i, 32'h0, 2'b00, 4'd0, 4'd0, "R2");
        cmp_all("R2");
    endtask

    task automatic t_dual();
        ins(2'b11, 32'hA0A0, 32'hB0B0, 2'b00, 4'd0, 4'd0, "R3");
        ins(2'b10, 32'h0, 32'hC0C0, 2'b00, 4'd0, 4'd0, "R3");
        cmp_all("R3");
    endtask

    task automatic t_fill();
        for (int i = 0; i < DEPTH + 4; i++) ins(2'b01, 32'h200 + i, 32'h0, 2'b00, 4'd0, 4'd0, "R4");
        @(negedge clk);
        rd_en[0] = 1'b1; rd_pos[0] = PW'(DEPTH-1);
        #1;
        check("R4", "deepest entry", rd_data[0], 32'h204);
        rd_en = '0;
        cmp_all("R4");
    endtask

    task automatic t_save();
        ins(2'b01, 32'h300, 32'h0, 2'b01, 4'd5, 4'd0, "R7");
        cmp_all("R7");
        ins(2'b00, 32'h0, 32'h0, 2'b11, 4'd0, 4'd3, "R7");
        cmp_all("R7");
    endtask

    task automatic t_ovf();
        ins(2'b11, 32'h400, 32'h401, 2'b11, 4'd2, 4'd7, "R8");
        cmp_all("R8");
        ins(2'b11, 32'h410, 32'h411, 2'b01, 4'd4, 4'd0, "R8");
        cmp_all("R8");
    endtask

    task automatic t_idle();
        repeat (4) @(posedge clk);
        cmp_all("R9");
    endtask

    task automatic t_save_empty();
        t_reset();
        ins(2'b00, 32'h0, 32'h0, 2'b01, 4'd3, 4'd0, "R10");
        ins(2'b01, 32'h500, 32'h0, 2'b00, 4'd0, 4'd0, "R10");
        cmp_all("R10");
    endtask

    initial begin
        wr_vld = '0; wr_data = '0; sv_vld = '0; sv_pos = '0; rd_en = '0; rd_pos = '0;
        mdl_clear();
        t_reset();
        t_single();
        t_dual();
        t_fill();
        t_save();
        t_ovf();
        t_idle();
        t_save_empty();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule